// File: doc/BRIEF.md
# Fail-First Vector Element Sequencer

This block walks the element indices of one vector operation, one element at a time from index 0 upwards, and decides when the operation may stop early. A start pulse captures the vector length, the fail-first mode, whether the operation produces a condition-register (CR) result, and which CR bit to test with which sense. The sequencer then offers each index on a valid/ready issue port. It waits for that element's in-order response, which carries an exception flag and a 4-bit CR field, before it moves on to the next index.

Two early-stop rules apply. In load/store fail-first mode, a fault on the first element is a normal trap. A fault on any later element quietly shortens the vector length to the number of elements already finished. In data-driven mode, when the operation produces a CR result, a successful branch-style test of the selected CR bit cancels the current element and all later ones, and the length is cut to the current index. A commit-enable accompanies every response, so that cancelled or faulting elements never write their results. A single-cycle done pulse presents the final length, which then holds until the next start.

The controller has four named states. IDLE waits for start. It goes to ISSUE, or to DONE directly when the length is zero. ISSUE offers the current index and goes to WAIT on a handshake. WAIT takes a response and goes either back to ISSUE with the next index, or to DONE on the last element, a trap or a truncation. DONE lasts exactly one cycle and returns to IDLE.

Top module: `ffseq`

## Requirements
- R1: In load/store mode (mode code 1), an exception reported for element 0 ends the operation with trap_o high alongside done_o. vl_o equals the captured length, and element 0 is not committed.
- R2: In load/store mode, an exception reported for element i with i of 1 or more raises no trap. vl_o becomes i, element i is not committed, and no element above i is issued.
- R3: In mode code 0 (no fail-first), mode code 2 and the reserved code 3, an exception on any element traps. vl_o is left at the captured length, and the faulting element is not committed.
- R4: In data-driven mode (code 2) with rc_i set at start, a successful CR test on element i cancels element i (commit_o low) and every later one. vl_o becomes i and no trap is raised.
- R5: The CR test reads bit test_sel_i of resp_cr_i, where index 0 is the least significant bit. With test_sense_i = 1 the test succeeds when that bit is 1. With test_sense_i = 0 it succeeds when that bit is 0.
- R6: The CR field is ignored, and all elements run, whenever the mode is not 2 or rc_i was low at start.
- R7: Without an exception or a terminating test, indices 0 to VL-1 are issued in ascending order and each is committed. vl_o then equals vl_i.
- R8: A start with vl_i = 0 gives done_o in the next cycle, with no element issued and vl_o = 0.
- R9: done_o is high for exactly one cycle, the cycle after the final response is accepted. vl_o holds its value from then until the next start.
- R10: elem_valid_o and elem_idx_o hold steady until elem_ready_i is seen. The next index is offered only after the previous element's response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start pulse, sampled in IDLE |
| vl_i | input | VL_W | Vector length for the new operation |
| mode_i | input | 2 | 0 none, 1 load/store fail-first, 2 data-driven, 3 treated as none |
| rc_i | input | 1 | Operation produces a CR result |
| test_sel_i | input | SEL_W | CR bit index to test |
| test_sense_i | input | 1 | 1: test succeeds on bit set; 0: on bit clear |
| elem_valid_o | output | 1 | An element index is offered |
| elem_ready_i | input | 1 | Downstream accepts the offered index |
| elem_idx_o | output | VL_W | Offered element index |
| resp_valid_i | input | 1 | Response for the issued element is present |
| resp_exc_i | input | 1 | Element raised an exception |
| resp_cr_i | input | CR_W | CR field produced by the element |
| commit_o | output | 1 | Commit the responding element's result |
| done_o | output | 1 | One-cycle completion pulse |
| trap_o | output | 1 | Trap request, valid with done_o |
| vl_o | output | VL_W | Final vector length |

## Verification
Fixed-seed random operations cover every mode code with rc_i both set and clear, random per-element CR fields, random fault positions and random handshake stalls. These runs tell a full run apart from a trap and from each of the two truncation kinds. Directed cases place a fault on element 0 against a later element, and this separates the trap from the silent truncation in load/store mode. Each test bit index is tried with both senses on a CR pattern where only one element matches, which exposes a wrong bit index or an inverted sense. A zero length and the reserved mode code round out the corner cases.

// File: rtl/ffseq_pkg.sv
package ffseq_pkg;
    typedef enum logic [1:0] {
        FF_NONE = 2'd0,
        FF_LDST = 2'd1,
        FF_DATA = 2'd2,
        FF_RSVD = 2'd3
    } ff_mode_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_DONE  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/ffseq_cr_test.sv
module ffseq_cr_test #(
    parameter int CR_W  = 4,
    localparam int SEL_W = $clog2(CR_W)
) (
    input  logic [CR_W-1:0]  cr,
    input  logic [SEL_W-1:0] sel,
    input  logic             sense,
    output logic             hit
);
    logic [CR_W-1:0] match;

    for (genvar b = 0; b < CR_W; b++) begin : g_bit
        assign match[b] = (cr[b] == sense) && (sel == SEL_W'(b));
    end

    assign hit = |match;
endmodule

// File: rtl/ffseq_judge.sv
module ffseq_judge
    import ffseq_pkg::*;
(
    input  ff_mode_e mode,
    input  logic     rc,
    input  logic     first,
    input  logic     exc,
    input  logic     cr_hit,
    output logic     trap,
    output logic     kill,
    output logic     pass
);
    logic ldst_mode;
    logic data_on;
    logic soft_fault;

    always_comb begin
        ldst_mode  = (mode == FF_LDST);
        data_on    = (mode == FF_DATA) && rc;
        soft_fault = exc && ldst_mode && !first;
        trap       = exc && !soft_fault;
        kill       = soft_fault || (!exc && data_on && cr_hit);
        pass       = !trap && !kill;
    end
endmodule

// File: rtl/ffseq.sv
module ffseq
    import ffseq_pkg::*;
#(
    parameter int VL_W = 7,
    parameter int CR_W = 4,
    localparam int SEL_W = $clog2(CR_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [VL_W-1:0]  vl_i,
    input  logic [1:0]       mode_i,
    input  logic             rc_i,
    input  logic [SEL_W-1:0] test_sel_i,
    input  logic             test_sense_i,
    output logic             elem_valid_o,
    input  logic             elem_ready_i,
    output logic [VL_W-1:0]  elem_idx_o,
    input  logic             resp_valid_i,
    input  logic             resp_exc_i,
    input  logic [CR_W-1:0]  resp_cr_i,
    output logic             commit_o,
    output logic             done_o,
    output logic             trap_o,
    output logic [VL_W-1:0]  vl_o
);
    seq_state_e       state_q, state_d;
    logic [VL_W-1:0]  idx_q, cap_q, vl_q;
    ff_mode_e         mode_q;
    logic             rc_q, sense_q, trap_q;
    logic [SEL_W-1:0] sel_q;

    logic cr_hit, j_trap, j_kill, j_pass, last_elem, resp_take;

    ffseq_cr_test #(.CR_W(CR_W)) u_cr_test (
        .cr    (resp_cr_i),
        .sel   (sel_q),
        .sense (sense_q),
        .hit   (cr_hit)
    );

    ffseq_judge u_judge (
        .mode   (mode_q),
        .rc     (rc_q),
        .first  (idx_q == '0),
        .exc    (resp_exc_i),
        .cr_hit (cr_hit),
        .trap   (j_trap),
        .kill   (j_kill),
        .pass   (j_pass)
    );

    assign last_elem = (idx_q == cap_q - VL_W'(1));
    assign resp_take = (state_q == S_WAIT) && resp_valid_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = (vl_i == '0) ? S_DONE : S_ISSUE;
            S_ISSUE: if (elem_ready_i) state_d = S_WAIT;
            S_WAIT:  if (resp_valid_i)
                         state_d = (!j_pass || last_elem) ? S_DONE : S_ISSUE;
            S_DONE:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // operation registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            cap_q   <= '0;
            vl_q    <= '0;
            mode_q  <= FF_NONE;
            rc_q    <= 1'b0;
            sel_q   <= '0;
            sense_q <= 1'b0;
            trap_q  <= 1'b0;
        end else if (state_q == S_IDLE && start_i) begin
            idx_q   <= '0;
            cap_q   <= vl_i;
            mode_q  <= ff_mode_e'(mode_i);
            rc_q    <= rc_i;
            sel_q   <= test_sel_i;
            sense_q <= test_sense_i;
            trap_q  <= 1'b0;
            if (vl_i == '0) vl_q <= '0;
        end else if (resp_take) begin
            if (j_trap) begin
                vl_q   <= cap_q;
                trap_q <= 1'b1;
            end else if (j_kill) begin
                vl_q   <= idx_q;
            end else if (last_elem) begin
                vl_q   <= cap_q;
            end else begin
                idx_q  <= idx_q + VL_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        elem_valid_o = (state_q == S_ISSUE);
        elem_idx_o   = idx_q;
        commit_o     = resp_take && j_pass;
        done_o       = (state_q == S_DONE);
        trap_o       = done_o && trap_q;
        vl_o         = vl_q;
    end

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r9_vl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !start_i) |=> $stable(vl_o));
    a_r2_vl_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (vl_o <= cap_q));
    a_r1_trap_keeps_vl: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (vl_o == cap_q));
    a_r4_no_commit_cancelled: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (!j_kill && !j_trap));
    a_r10_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid_o |-> (elem_idx_o < cap_q));
    a_r10_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid_o && !elem_ready_i) |=> (elem_valid_o && $stable(elem_idx_o)));
endmodule

// File: tb/ffseq_bench.sv
`timescale 1ns/1ps
module ffseq_bench;
    localparam int VL_W = 7;
    localparam int CR_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [VL_W-1:0] vl_i = '0;
    logic [1:0] mode_i = '0;
    logic rc_i = 1'b0;
    logic [1:0] test_sel_i = '0;
    logic test_sense_i = 1'b0;
    logic elem_valid_o, elem_ready_i;
    logic [VL_W-1:0] elem_idx_o;
    logic resp_valid_i, resp_exc_i;
    logic [CR_W-1:0] resp_cr_i;
    logic commit_o, done_o, trap_o;
    logic [VL_W-1:0] vl_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] cr_tab [64];

    always #10 clk = ~clk;

    ffseq u_ffseq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
        .mode_i(mode_i), .rc_i(rc_i), .test_sel_i(test_sel_i),
        .test_sense_i(test_sense_i), .elem_valid_o(elem_valid_o),
        .elem_ready_i(elem_ready_i), .elem_idx_o(elem_idx_o),
        .resp_valid_i(resp_valid_i), .resp_exc_i(resp_exc_i),
        .resp_cr_i(resp_cr_i), .commit_o(commit_o), .done_o(done_o),
        .trap_o(trap_o), .vl_o(vl_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference model built from the requirements
    task automatic model(input int vl, input int mode, input bit rc, input int sel,
                         input bit sense, input int exc_at,
                         output int e_vl, output int e_trap, output int e_issued,
                         output int e_commits, output string tag);
        e_vl = vl; e_trap = 0; e_issued = vl; e_commits = 0;
        tag = (mode == 2 && rc) ? "R7" : "R6";
        if (vl == 0) tag = "R8";
        for (int k = 0; k < vl; k++) begin
            if (k == exc_at) begin
                e_issued = k + 1;
                if (mode == 1 && k > 0) begin e_vl = k; tag = "R2"; end
                else begin e_trap = 1; tag = (mode == 1) ? "R1" : "R3"; end
                return;
            end
            if (mode == 2 && rc && (cr_tab[k][sel] == sense)) begin
                e_issued = k + 1; e_vl = k; tag = "R4";
                return;
            end
            e_commits++;
        end
    endtask

    task automatic run_op(input int vl, input int mode, input bit rc, input int sel,
                          input bit sense, input int exc_at, input bit stalls);
        int e_vl, e_trap, e_issued, e_commits;
        string tag;
        int k = 0;
        int commits = 0;
        int order_bad = 0;
        int held_bad = 0;
        logic [VL_W-1:0] vl_seen;
        model(vl, mode, rc, sel, sense, exc_at, e_vl, e_trap, e_issued, e_commits, tag);
        @(negedge clk);
        start_i = 1'b1; vl_i = VL_W'(vl); mode_i = 2'(mode); rc_i = rc;
        test_sel_i = 2'(sel); test_sense_i = sense;
        @(negedge clk);
        start_i = 1'b0;
        forever begin
            #1;
            if (done_o) break;
            if (!elem_valid_o) begin @(negedge clk); continue; end
            if (elem_idx_o != VL_W'(k)) order_bad++;
            if (stalls) begin
                for (int d = 0; d < int'($urandom_range(0, 2)); d++) begin
                    @(negedge clk); #1;
                    if (!elem_valid_o || elem_idx_o != VL_W'(k)) held_bad++;
                end
            end
            @(negedge clk); elem_ready_i = 1'b1;
            @(negedge clk); elem_ready_i = 1'b0;
            if (stalls) begin
                for (int d = 0; d < int'($urandom_range(0, 2)); d++) begin
                    #1; if (elem_valid_o || done_o) held_bad++;
                    @(negedge clk);
                end
            end
            resp_valid_i = 1'b1;
            resp_exc_i = (k == exc_at);
            resp_cr_i = cr_tab[k];
            #1; if (commit_o) commits++;
            @(negedge clk);
            resp_valid_i = 1'b0; resp_exc_i = 1'b0;
            k++;
        end
        chk(vl_o == VL_W'(e_vl), tag, "final vl", int'(vl_o), e_vl);
        chk(trap_o == e_trap[0], tag, "trap", int'(trap_o), e_trap);
        chk(k == e_issued, tag, "issued count", k, e_issued);
        chk(commits == e_commits, tag, "commits", commits, e_commits);
        chk(order_bad == 0, "R10", "index order errors", order_bad, 0);
        chk(held_bad == 0, "R10", "offer/advance errors", held_bad, 0);
        vl_seen = vl_o;
        @(negedge clk); #1;
        chk(!done_o, "R9", "done width", int'(done_o), 0);
        @(negedge clk); #1;
        chk(vl_o == vl_seen, "R9", "vl hold", int'(vl_o), int'(vl_seen));
    endtask

    initial begin
        #(20ns * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        elem_ready_i = 1'b0; resp_valid_i = 1'b0; resp_exc_i = 1'b0; resp_cr_i = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(!done_o && !elem_valid_o && !trap_o && vl_o == '0, "R9", "reset state",
            int'({done_o, elem_valid_o, trap_o}), 0);
        rst_n = 1'b1;

        foreach (cr_tab[i]) cr_tab[i] = 4'h0;
        run_op(0, 2, 1, 0, 0, -1, 0);          // R8 zero length
        run_op(5, 1, 0, 0, 0, 0, 0);           // R1 fault on first element
        run_op(6, 1, 0, 0, 0, 3, 1);           // R2 fault on element 3
        run_op(6, 0, 0, 0, 0, 2, 0);           // R3 normal trap
        run_op(4, 3, 1, 0, 0, 1, 0);           // R3 reserved code
        run_op(7, 2, 0, 0, 0, -1, 1);          // R6 rc clear: all zero bits would hit
        run_op(7, 3, 1, 0, 0, -1, 0);          // R6 reserved code ignores CR
        run_op(9, 1, 0, 0, 1, -1, 1);          // R7 full run
        for (int s = 0; s < 4; s++) begin      // R5 each bit, sense 1
            foreach (cr_tab[i]) cr_tab[i] = 4'h0;
            cr_tab[4] = 4'(1 << s);
            run_op(8, 2, 1, s, 1, -1, 0);
        end
        for (int s = 0; s < 4; s++) begin      // R5 each bit, sense 0
            foreach (cr_tab[i]) cr_tab[i] = 4'hF;
            cr_tab[4] = ~4'(1 << s);
            run_op(8, 2, 1, s, 0, -1, 0);
        end

        for (int n = 0; n < 300; n++) begin
            int vl, mode, exc_at;
            foreach (cr_tab[i]) cr_tab[i] = 4'($urandom);
            vl = int'($urandom_range(0, 20));
            mode = int'($urandom_range(0, 3));
            exc_at = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 20)) : -1;
            run_op(vl, mode, 1'($urandom), int'($urandom_range(0, 3)),
                   1'($urandom), exc_at, 1'b1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule